// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block is the device end of a serial flash memory that serves one command: the continuous byte read. A host selects it by pulling the active-low select line down. The host then clocks in an 8-bit opcode and a 24-bit byte address, and clocks out data for as long as it keeps the device selected. The block runs on its own system clock. It oversamples the serial clock, select and data-in lines through synchronisers, and it acts on the edges it detects.

After the address, bytes are read from an internal byte array, starting at the given location. Each byte is sent most significant bit first. The address advances by one after every byte, and it wraps from the last array entry back to zero, so a single command can read forever. The serial output has a separate output-enable. It is released whenever the device is not sending data. A busy input marks an erase, program or write cycle in progress; a read that arrives while it is set is dropped without any output. A load port lets a test environment fill the array directly.

Top module: `spi_flash_reader`

## Requirements
- R1: While out of reset and with `cs_n` held high for 3 or more clock cycles, `sdo_oe` is 0. It is 0 directly after reset.
- R2: After `cs_n` falls, the first 8 `sck` rising edges capture the opcode from `sdi`, MSB first. Opcode 0x03 selects the read.
- R3: The next 24 rising edges capture the byte address, MSB first. Only the low `MEM_AW` bits select the array entry, and the upper bits are ignored.
- R4: During the 32 opcode and address clocks, `sdo_oe` stays 0.
- R5: Data bits change only after `sck` falling edges, at most 4 clock cycles after the edge. The first bit follows the fall of the 32nd `sck` clock. Each byte is sent MSB first with `sdo_oe` at 1.
- R6: After each complete byte, the read address increments by one.
- R7: After the entry at address 2^`MEM_AW`−1, the read continues at address 0.
- R8: Raising `cs_n` at any point ends the command, and `sdo_oe` returns to 0 within 4 clock cycles. Partially transferred bits are discarded, and the next selection decodes a fresh opcode.
- R9: If `busy` is 1 when the opcode or the address completes, the command is dropped: `sdo_oe` stays 0 until `cs_n` rises.
- R10: Any opcode other than 0x03 leaves `sdo_oe` at 0 until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must be several times faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| busy | input | 1 | High while an erase, program or write cycle runs |
| load_en | input | 1 | Write strobe of the array load port |
| load_addr | input | MEM_AW | Array entry written by the load port |
| load_data | input | 8 | Byte written by the load port |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
Some properties are checked on every cycle from the ports alone: the output enable stays low while the device is deselected and throughout the 32 header clocks; every change of the driven data bit follows closely after an `sck` fall; and the output enable drops only shortly after `cs_n` has been high. The byte values themselves, the auto-increment, the wrap at the top of the array, the masking of upper address bits, and the silent rejection of a busy or unknown command depend on array content and on the sequence of commands. These only the bench's scoreboard scenarios can show.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } rd_state_e;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam int         CMD_BITS  = 8;
    localparam int         ADDR_BITS = 24;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            bytes_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = bytes_q[rd_addr];
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
    import spi_rd_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              busy,
    input  logic              load_en,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [7:0]        load_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(ADDR_BITS);

    typedef struct packed {
        rd_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [ADDR_BITS-1:0]  sh;
        logic [MEM_AW-1:0]     addr;
        logic [2:0]            bitn;
        logic                  sck_p;
        logic                  dout;
        logic                  oe;
    } regs_t;

    regs_t r_q, r_d;

    logic cs_s, sck_s, sdi_s;
    logic [7:0] rd_byte;

    spi_rd_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, sdi}),
        .q     ({cs_s, sck_s, sdi_s})
    );

    spi_rd_mem #(
        .AW (MEM_AW)
    ) u_mem (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (r_q.addr),
        .rd_data (rd_byte)
    );

    logic                 rise, fall;
    logic [ADDR_BITS-1:0] shifted;

    always_comb begin
        r_d       = r_q;
        r_d.sck_p = sck_s;
        rise      = sck_s & ~r_q.sck_p;
        fall      = ~sck_s & r_q.sck_p;
        shifted   = {r_q.sh[ADDR_BITS-2:0], sdi_s};

        if (cs_s) begin
            r_d.st   = ST_IDLE;
            r_d.cnt  = '0;
            r_d.bitn = '0;
            r_d.oe   = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st  = ST_CMD;
                    r_d.cnt = '0;
                    r_d.sh  = '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        r_d.sh = shifted;
                        if (r_q.cnt == CNT_W'(CMD_BITS - 1)) begin
                            r_d.cnt = '0;
                            if (shifted[7:0] == OP_READ && !busy) begin
                                r_d.st = ST_ADDR;
                            end else begin
                                r_d.st = ST_SKIP;
                            end
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        r_d.sh = shifted;
                        if (r_q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                            r_d.cnt = '0;
                            if (busy) begin
                                r_d.st = ST_SKIP;
                            end else begin
                                r_d.st   = ST_DATA;
                                r_d.addr = shifted[MEM_AW-1:0];
                                r_d.bitn = '0;
                            end
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        r_d.dout = rd_byte[~r_q.bitn];
                        r_d.oe   = 1'b1;
                        r_d.bitn = r_q.bitn + 1'b1;
                        if (r_q.bitn == 3'd7) begin
                            r_d.addr = r_q.addr + 1'b1;
                        end
                    end
                end
                ST_SKIP: begin
                    r_d.oe = 1'b0;
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, addr: '0, bitn: '0,
                     sck_p: 1'b0, dout: 1'b0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo    = r_q.dout;
    assign sdo_oe = r_q.oe;
endmodule

// File: rtl/spi_rd_chk.sv
module spi_rd_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic sdo,
    input logic sdo_oe
);
    logic [1:0] hi_cnt;
    logic [1:0] lo_cnt;
    logic [2:0] hi_age;
    logic [2:0] fall_age;
    logic [5:0] rise_cnt;
    logic       sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            hi_age   <= '0;
            fall_age <= 3'd7;
            rise_cnt <= '0;
            sck_q    <= 1'b0;
        end else begin
            sck_q    <= sck;
            hi_cnt   <= cs_n  ? ((hi_cnt == 2'd3) ? hi_cnt : hi_cnt + 1'b1) : 2'd0;
            lo_cnt   <= !cs_n ? ((lo_cnt == 2'd3) ? lo_cnt : lo_cnt + 1'b1) : 2'd0;
            hi_age   <= cs_n  ? 3'd0 : ((hi_age == 3'd7) ? hi_age : hi_age + 1'b1);
            fall_age <= (sck_q && !sck) ? 3'd0 :
                        ((fall_age == 3'd7) ? fall_age : fall_age + 1'b1);
            if (hi_cnt == 2'd3) begin
                rise_cnt <= '0;
            end else if (!sck_q && sck && rise_cnt != 6'd63) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == 2'd3) |-> !sdo_oe);

    a_r4_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_cnt == 2'd3 && rise_cnt < 6'd32) |-> !sdo_oe);

    a_r5_sdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && sdo != $past(sdo)) |-> (fall_age <= 3'd3));

    a_r8_oe_drop_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> (hi_age <= 3'd3));
endmodule

bind spi_flash_reader spi_rd_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sck    (sck),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
);

// File: tb/spi_flash_reader_test.sv
module spi_flash_reader_test;
    localparam int MEM_AW = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic busy = 1'b0;
    logic load_en = 1'b0;
    logic [MEM_AW-1:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic sdo, sdo_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [8:0] got_q [$];

    always #4 clk = ~clk;

    spi_flash_reader #(.MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .busy(busy), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [7:0] ref_byte(input int idx);
        int v;
        v = (idx * 37 + 11) ^ (idx >> 3);
        return v[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic half();
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic so, output logic oe);
        sdi = b;
        half();
        so  = sdo;
        oe  = sdo_oe;
        sck = 1'b1;
        half();
        sck = 1'b0;
    endtask

    task automatic send_header(input logic [7:0] op, input logic [23:0] a,
                               input string req);
        logic so, oe;
        logic any_oe;
        logic [31:0] hdr;
        hdr = {op, a};
        any_oe = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            xfer_bit(hdr[i], so, oe);
            any_oe |= oe;
        end
        chk(any_oe == 1'b0, req, any_oe, 0);
    endtask

    // Scoreboard driver: full command, expected bytes pushed when data is due.
    task automatic txn(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                       input logic bsy, input bit want_data, input string req);
        logic so, oe;
        logic [7:0] val;
        logic all_oe, any_oe;
        cs_n = 1'b0;
        busy = bsy;
        half();
        send_header(op, a, "R4 header quiet");
        for (int k = 0; k < nbytes; k++) begin
            if (want_data) begin
                exp_q.push_back(ref_byte((int'(a[MEM_AW-1:0]) + k) % DEPTH));
                tag_q.push_back(req);
            end
            all_oe = 1'b1;
            any_oe = 1'b0;
            for (int b = 0; b < 8; b++) begin
                xfer_bit(1'b0, so, oe);
                val[7-b] = so;
                all_oe &= oe;
                any_oe |= oe;
            end
            if (want_data) got_q.push_back({all_oe, val});
            else chk(any_oe == 1'b0, req, any_oe, 0);
        end
        half();
        cs_n = 1'b1;
        busy = 1'b0;
        repeat (5) @(negedge clk);
        chk(sdo_oe == 1'b0, "R8 release after deselect", sdo_oe, 0);
        repeat (6) @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [8:0] g;
                logic [7:0] e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(g == {1'b1, e}, t, g, {1'b1, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic so, oe;
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1'b0, "R1 reset state", sdo_oe, 0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = MEM_AW'(i);
            load_data = ref_byte(i);
        end
        @(negedge clk);
        load_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b0, "R1 idle deselected", sdo_oe, 0);

        // R2 R5 R6: plain read, MSB first, incrementing
        txn(8'h03, 24'h000010, 4, 1'b0, 1'b1, "R2 R5 R6 sequential read");
        // R7: wrap from top entry to zero
        txn(8'h03, 24'h0000FD, 5, 1'b0, 1'b1, "R7 wrap to zero");
        // R3: upper address bits ignored
        txn(8'h03, 24'h5A0003, 3, 1'b0, 1'b1, "R3 upper bits ignored");
        // R9: busy read dropped
        txn(8'h03, 24'h000020, 2, 1'b1, 1'b0, "R9 busy read dropped");
        // R10: unknown opcode
        txn(8'h0B, 24'h000020, 2, 1'b0, 1'b0, "R10 unknown opcode");

        // R8: abort mid-byte, then a fresh command decodes normally
        cs_n = 1'b0;
        half();
        send_header(8'h03, 24'h000040, "R4 header quiet");
        for (int b = 0; b < 3; b++) xfer_bit(1'b0, so, oe);
        chk(sdo_oe == 1'b1, "R5 drive during data", sdo_oe, 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b0, "R8 abort mid byte", sdo_oe, 0);
        repeat (8) @(negedge clk);
        txn(8'h03, 24'h000080, 2, 1'b0, 1'b1, "R8 fresh decode after abort");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule